// File: doc/BRIEF.md
# Two-Wire Control Register Target for a Clock Generator

This block is the serial configuration port of a clock generator. It sits on an SMBus-style two-wire bus as a target only and holds ten 8-bit control bytes that steer the generator's outputs and PLL. A master writes the bytes with a block write to one address and reads them back from the address one above it. Transfers to any other address are not acknowledged and leave the block untouched until the next START.

A write carries a command byte and a byte-count byte before any data. Both are acknowledged and then discarded. Data bytes always start at register 0 and step up by one per byte. A read returns register bytes from register 0 upward until the master answers with a NACK. Three bits of register 0 show live hardware state: the two latched frequency-select straps and the internal PCI-stop level. Register 6 is a fixed signature. Register 9 bit 0 chooses where the PLL divider values come from: a fixed table supplied on input pins, or the register fields.

The bus lines pass through a two-flop synchronizer and a glitch filter before START, STOP and SCL edges are detected. All register contents survive any bus activity and return to their defaults only on the power-on reset.

Top module: `smb_ctlreg`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged by pulling SDA low in the ninth clock. Any other address gets no acknowledge, and the rest of that transfer changes nothing.
- R2: In a write, the first two bytes after the address are a command byte and a byte count. Both are acknowledged and neither is stored.
- R3: Write data bytes go to register 0, then 1, 2 and so on, and each one is acknowledged. Bytes past register 9 are acknowledged and dropped.
- R4: Register 0 bit 3 reads the live `pci_stop_i` level, and bits 2:1 read `strap_i[1:0]`. Writes cannot change these bits.
- R5: Register 6 always reads 0x13. A write to it is acknowledged and has no effect.
- R6: After power-on reset the registers read 0x01 (register 0, with bits 3:1 live), 0x87, 0x7F, 0xDF, 0x3F, 0x40, 0x13, then 0x00 for registers 7, 8 and 9.
- R7: Register contents change only through acknowledged data bytes. Transfers to other addresses leave them unchanged, and only reset restores the defaults.
- R8: When register 9 bit 0 is 0, `pll_n_o` equals `rom_n_i` and `pll_r_o` equals `rom_r_i`. When it is 1, `pll_n_o` is register 8 bits 6:0 and `pll_r_o` is register 9 bits 7:1.
- R9: A read sends register bytes MSB first, starting at register 0 and counting up (0xFF past register 9). After a master NACK the target releases SDA and drives it no further.
- R10: A START in the middle of a byte abandons that byte without storing it and restarts address matching.
- R11: `cfg_o` byte i (bits 8i+7:8i) always shows register i as a bus read would return it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| strap_i | input | 2 | Latched frequency-select straps |
| pci_stop_i | input | 1 | Internal PCI-stop state |
| rom_n_i | input | 7 | Table N divider value |
| rom_r_i | input | 7 | Table R divider value |
| pll_n_o | output | 7 | Selected N divider |
| pll_r_o | output | 7 | Selected R divider |
| cfg_o | output | 80 | All ten register bytes as read back |

## Verification
Each SCL or SDA change reaches the detector about FILT_LEN+3 clocks after it happens on the line. So the target's acknowledge or data bit appears that many cycles after the falling SCL edge, and a stored byte reaches `cfg_o` and the PLL outputs the same number of cycles after the eighth falling edge. The bench holds every SCL phase for 10 clocks and samples SDA halfway through the high phase, well after the filtered edge has taken effect. Register and divider outputs are compared only after the STOP has settled. Read bytes go from the driver into a queue of expected values, and a monitor process pops each one when a byte completes.

// File: rtl/smb_ctlreg.sv
module smb_ctlreg #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int FILT_LEN = 3,
  parameter int NREG = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_i,
  input  logic              pci_stop_i,
  input  logic [6:0]        rom_n_i,
  input  logic [6:0]        rom_r_i,
  output logic [6:0]        pll_n_o,
  output logic [6:0]        pll_r_o,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam int IW = $clog2(NREG) + 1;
  localparam logic [IW-1:0] NREG_W = IW'(NREG);
  localparam logic [7:0] SIG = 8'h13;

  typedef enum logic [2:0] {IDLE, RXB, RACK, TXB, MACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_CMD, P_CNT, P_DATA} ph_t;

  function automatic logic [7:0] dflt(int i);
    case (i)
      0: dflt = 8'h01;
      1: dflt = 8'h87;
      2: dflt = 8'h7F;
      3: dflt = 8'hDF;
      4: dflt = 8'h3F;
      5: dflt = 8'h40;
      default: dflt = 8'h00;
    endcase
  endfunction

  logic [1:0] s1, s2, flt, fq;
  logic [CW-1:0] fcnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; flt <= 2'b11; fq <= 2'b11;
      for (int k = 0; k < 2; k++) fcnt[k] <= '0;
    end else begin
      s1 <= {sda_i, scl_i};
      s2 <= s1;
      fq <= flt;
      for (int k = 0; k < 2; k++) begin
        if (s2[k] == flt[k]) fcnt[k] <= '0;
        else if (fcnt[k] == CW'(FILT_LEN - 1)) begin
          flt[k] <= s2[k];
          fcnt[k] <= '0;
        end else fcnt[k] <= fcnt[k] + CW'(1);
      end
    end
  end

  wire scl_rise = flt[0] & ~fq[0];
  wire scl_fall = ~flt[0] & fq[0];
  wire start_det = flt[0] & fq[0] & fq[1] & ~flt[1];
  wire stop_det  = flt[0] & fq[0] & ~fq[1] & flt[1];

  st_t st;
  ph_t ph;
  logic [3:0] bcnt;
  logic [7:0] sh;
  logic rd, got_ack;
  logic [IW-1:0] idx;
  logic [7:0] regs [NREG];
  logic [7:0] rview [NREG];
  logic [7:0] txd;
  logic [NREG*8-1:0] regs_flat;

  always_comb begin
    for (int i = 0; i < NREG; i++) rview[i] = regs[i];
    rview[0][3:1] = {pci_stop_i, strap_i};
    rview[6] = SIG;
    txd = 8'hFF;
    for (int i = 0; i < NREG; i++) if (idx == IW'(i)) txd = rview[i];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_o[g*8 +: 8] = rview[g];
    assign regs_flat[g*8 +: 8] = regs[g];
  end

  wire byte_done = (st == RXB) && scl_fall && (bcnt == 4'd8);
  wire addr_hit  = (sh[7:1] == DEV_ADDR);
  wire wr_en     = byte_done && (ph == P_DATA) && (idx < NREG_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (i != 6 && idx == IW'(i)) regs[i] <= sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ph <= P_ADDR; bcnt <= '0; sh <= '0;
      rd <= 1'b0; got_ack <= 1'b0; idx <= '0; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= RXB; ph <= P_ADDR; bcnt <= '0; idx <= '0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        RXB: begin
          if (scl_rise) begin
            sh <= {sh[6:0], flt[1]};
            bcnt <= bcnt + 4'd1;
          end else if (byte_done) begin
            if (ph == P_ADDR && !addr_hit) st <= IDLE;
            else begin
              sda_oe <= 1'b1;
              st <= RACK;
              if (ph == P_ADDR) rd <= sh[0];
              if (ph == P_DATA && idx < NREG_W) idx <= idx + IW'(1);
            end
          end
        end
        RACK: if (scl_fall) begin
          bcnt <= '0;
          if (ph == P_ADDR && rd) begin
            st <= TXB;
            sh <= txd;
            sda_oe <= ~txd[7];
            if (idx < NREG_W) idx <= idx + IW'(1);
          end else begin
            sda_oe <= 1'b0;
            st <= RXB;
            if (ph != P_DATA) ph <= ph_t'(ph + 2'd1);
          end
        end
        TXB: if (scl_fall) begin
          if (bcnt == 4'd7) begin
            sda_oe <= 1'b0;
            st <= MACK;
            got_ack <= 1'b0;
          end else begin
            sh <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
            bcnt <= bcnt + 4'd1;
          end
        end
        MACK: begin
          if (scl_rise) begin
            if (flt[1]) st <= IDLE;
            else got_ack <= 1'b1;
          end else if (scl_fall && got_ack) begin
            st <= TXB;
            bcnt <= '0;
            sh <= txd;
            sda_oe <= ~txd[7];
            if (idx < NREG_W) idx <= idx + IW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign pll_n_o = regs[9][0] ? regs[8][6:0] : rom_n_i;
  assign pll_r_o = regs[9][0] ? regs[9][7:1] : rom_r_i;

  // R1
  addr_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == P_ADDR && !addr_hit) |=> !sda_oe);

  // R1
  drive_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == RACK || st == TXB));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R10
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == RXB && bcnt == 4'd0 && !sda_oe));

  // R7
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));
endmodule

// File: tb/tb_smb_ctlreg.sv
module tb_smb_ctlreg;
  localparam int Q = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [1:0] strap = 2'b10;
  logic pci_stop = 1'b1;
  logic [6:0] rom_n = 7'h2A, rom_r = 7'h15;
  logic [6:0] pll_n, pll_r;
  logic [79:0] cfg;
  wire sda_ln = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  smb_ctlreg dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln), .sda_oe(sda_oe),
    .strap_i(strap), .pci_stop_i(pci_stop), .rom_n_i(rom_n), .rom_r_i(rom_r),
    .pll_n_o(pll_n), .pll_r_o(pll_r), .cfg_o(cfg)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [10];
  logic [7:0] wbuf [12];
  int exp_q[$];
  string tag_q[$];
  logic [7:0] got_byte;
  event byte_ev;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_view(int i);
    if (i >= 10) return 8'hFF;
    if (i == 6) return 8'h13;
    if (i == 0) return {model[0][7:4], pci_stop, strap, model[0][0]};
    return model[i];
  endfunction

  task automatic set_defaults();
    model[0] = 8'h01; model[1] = 8'h87; model[2] = 8'h7F; model[3] = 8'hDF;
    model[4] = 8'h3F; model[5] = 8'h40; model[6] = 8'h13;
    model[7] = 8'h00; model[8] = 8'h00; model[9] = 8'h00;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bstart();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(Q); scl_m = 0; tick(2);
    end
    sda_m = 1; tick(Q); scl_m = 1; tick(Q/2); ack = ~sda_ln; tick(Q/2);
    scl_m = 0; tick(2);
  endtask

  task automatic rbyte(input bit nack);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; tick(Q); scl_m = 1; tick(Q/2); b[i] = sda_ln; tick(Q/2);
      scl_m = 0; tick(2);
    end
    sda_m = nack; tick(Q); scl_m = 1; tick(Q); scl_m = 0; tick(2); sda_m = 1;
    got_byte = b;
    ->byte_ev;
    tick(2);
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [7:0] cnt, input int n);
    bit a;
    bstart();
    wbyte(8'hD2, a); check(a, "R1 write address ack", a, 1);
    wbyte(cmd, a); check(a, "R2 command ack", a, 1);
    wbyte(cnt, a); check(a, "R2 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], a); check(a, "R3 data ack", a, 1);
      if (i < 10 && i != 6) model[i] = wbuf[i];
    end
    bstop();
  endtask

  task automatic do_read(input int n);
    bit a;
    bstart();
    wbyte(8'hD3, a); check(a, "R1 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_view(i));
      tag_q.push_back($sformatf("R9 read byte %0d", i));
      rbyte(i == n - 1);
    end
    tick(Q);
    check(sda_oe == 0, "R9 SDA released after NACK", sda_oe, 0);
    bstop();
  endtask

  task automatic check_cfg(string tag);
    for (int i = 0; i < 10; i++)
      check(cfg[i*8 +: 8] == exp_view(i), $sformatf("%s cfg byte %0d", tag, i),
            cfg[i*8 +: 8], exp_view(i));
  endtask

  initial begin
    forever begin
      @(byte_ev);
      if (exp_q.size() == 0) check(0, "R9 unexpected byte", got_byte, 0);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got_byte == e[7:0], t, got_byte, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    set_defaults();
    tick(5); rst_n = 1; tick(5);
    check(sda_oe == 0, "R6 reset SDA idle", sda_oe, 0);
    check_cfg("R6 R11 R4 defaults");
    check(pll_n == rom_n && pll_r == rom_r, "R8 table source", {pll_n, pll_r}, {rom_n, rom_r});

    do_read(10);

    wbuf[0] = 8'hF0; wbuf[1] = 8'h12; wbuf[2] = 8'h34; wbuf[3] = 8'h56;
    wbuf[4] = 8'h78; wbuf[5] = 8'h9A; wbuf[6] = 8'hFF; wbuf[7] = 8'hBC;
    wbuf[8] = 8'h7E; wbuf[9] = 8'hC3; wbuf[10] = 8'h99;
    do_write(8'h55, 8'hAA, 11);
    check_cfg("R3 R2 R5 after write");
    check(cfg[7:0] == 8'hFC, "R4 live bits kept over write", cfg[7:0], 8'hFC);
    check(cfg[55:48] == 8'h13, "R5 signature after write", cfg[55:48], 8'h13);
    check(pll_n == 7'h7E, "R8 N from register", pll_n, 7'h7E);
    check(pll_r == 7'h61, "R8 R from register", pll_r, 7'h61);

    pci_stop = 0; strap = 2'b01; tick(2);
    check(cfg[7:0] == 8'hF2, "R4 live bits follow pins", cfg[7:0], 8'hF2);
    do_read(12);

    bstart();
    wbyte(8'hA4, a); check(!a, "R1 foreign address no ack", a, 0);
    wbyte(8'h00, a); wbyte(8'h00, a); wbyte(8'h11, a); wbyte(8'h22, a);
    bstop();
    check_cfg("R7 foreign transfer ignored");

    bstart();
    wbyte(8'hD2, a); wbyte(8'h01, a); wbyte(8'h01, a);
    for (int i = 7; i >= 4; i--) begin
      sda_m = 1'b0; tick(Q); scl_m = 1; tick(Q); scl_m = 0; tick(2);
    end
    bstart();
    wbyte(8'hD3, a); check(a, "R10 address after repeated START", a, 1);
    exp_q.push_back(exp_view(0)); tag_q.push_back("R10 partial byte not stored");
    rbyte(1);
    bstop();
    check(cfg[7:0] == 8'hF2, "R10 register 0 unchanged", cfg[7:0], 8'hF2);

    wbuf[0] = 8'h01; wbuf[1] = 8'h00; wbuf[2] = 8'h00; wbuf[3] = 8'h00;
    wbuf[4] = 8'h00; wbuf[5] = 8'h00; wbuf[6] = 8'h00; wbuf[7] = 8'h00;
    wbuf[8] = 8'h11; wbuf[9] = 8'h40;
    do_write(8'h00, 8'h0A, 10);
    check(pll_n == rom_n && pll_r == rom_r, "R8 back to table", {pll_n, pll_r}, {rom_n, rom_r});
    do_read(3);

    rst_n = 0; tick(3); rst_n = 1; tick(3);
    set_defaults();
    check_cfg("R7 R6 reset restores defaults");

    tick(20);
    check(exp_q.size() == 0, "R9 all read bytes seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule